// File: doc/BRIEF.md
# Chained Descriptor DMA Walker

This block is the internal DMA engine of a card host controller. Software builds a list of descriptors in system memory. Each descriptor is four 32-bit words: configuration, buffer byte count, buffer address and next-descriptor address. Software points the list base register at the first descriptor and switches the engine on. The engine fetches each descriptor through a single memory read/write port and checks that the descriptor belongs to hardware. It then moves the buffer between memory and the card data FIFO and hands the descriptor back by writing its configuration word with the ownership bit cleared.

The walk is steered by flag bits in the configuration word. Chaining takes the next pointer from word 3. An end-of-ring flag without chaining wraps back to the list base. A last flag ends the walk. The interrupt-suppress flag hides the completion of a buffer unless that buffer is the last one. The direction input selects transmit (memory to FIFO) or receive (FIFO to memory). Completion and error conditions collect in a status register whose bits are cleared by writing 1s. An interrupt line is raised while any status bit is set whose enable bit is also set.

Top module: `chain_dma_engine`

## Requirements
- R1: After reset, every register reads 0, `irq` is low and `memReq`, `txValid` and `rxPop` are low. Register map on `regAddr`: 0 control, 1 list base, 2 status, 3 interrupt enable.
- R2: A control write with bit 7 (engine on) set and bit 0 clear, made while idle, starts a walk at the list base. Each descriptor is read as four words at offsets 0, 4, 8 and 12, in the order configuration, byte count, buffer address, next pointer.
- R3: A fetched descriptor whose configuration bit 31 (ownership) is 0 stops the walk with no data movement and no write-back. It sets status bit 4 (descriptor invalid) and bit 9 (abnormal summary).
- R4: In transmit (`dirRx`=0), ceil(count/4) words are read from the buffer at increasing addresses and pushed into the FIFO in that order. A count of 0 moves nothing.
- R5: In receive (`dirRx`=1), ceil(count/4) words are popped from the FIFO and written to the buffer at increasing addresses.
- R6: After its buffer, a descriptor's configuration word is written back to its own address with bit 31 cleared and the other bits kept. If `cardErr` was high during that buffer, bit 30 is set in the write-back and status bits 5 and 9 are set.
- R7: The next descriptor comes from word 3 when configuration bit 4 (chained) is set. Otherwise it comes from the list base when bit 5 (end of ring) is set, and otherwise from the current address plus 16. Bit 2 (last) ends the walk after write-back.
- R8: After a write-back, status bit 0 (transmit done) or bit 1 (receive done), chosen by `dirRx`, is set together with bit 8 (normal summary). This happens only when configuration bit 1 (suppress) is clear or bit 2 (last) is set.
- R9: A byte count above `MAX_BUF_BYTES` is treated as an invalid descriptor: bits 4 and 9 are set, no data moves and no write-back takes place.
- R10: `memErr` on any acknowledged access stops the walk and sets status bit 2 (bus error) and bit 9.
- R11: Writing 1s to the status register clears those bits. `irq` is high exactly while status AND interrupt enable is non-zero.
- R12: A control write with bit 0 (soft reset) aborts the walk at once and returns the engine to idle. The control register reads back 0 afterwards. If a walk was active, status bits 10 (host abort) and 9 are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register select |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data (combinational on regAddr) |
| irq | output | 1 | Interrupt request |
| memReq | output | 1 | Memory access request, held until acknowledged |
| memWe | output | 1 | Memory access is a write |
| memAddr | output | 32 | Memory byte address |
| memWdata | output | 32 | Memory write data |
| memAck | input | 1 | Memory access done |
| memErr | input | 1 | Access failed, valid with memAck |
| memRdata | input | 32 | Read data, valid with memAck |
| dirRx | input | 1 | 1 = receive (FIFO to memory), 0 = transmit |
| cardErr | input | 1 | Card-side error indication |
| txValid | output | 1 | Transmit word available |
| txReady | input | 1 | FIFO accepts the transmit word |
| txData | output | 32 | Transmit word |
| rxValid | input | 1 | Receive word available |
| rxPop | output | 1 | Receive word taken |
| rxData | input | 32 | Receive word |

## Verification
The walk is exercised with single-descriptor lists of several byte counts in both directions, covering counts of zero, exact multiples and partial words. This tells word-count rounding apart from direction handling. A three-entry chained list with scattered pointers and a stalling FIFO shows that word 3 is followed and that the suppressed buffers give no completion. Two contiguous lists that end on a descriptor not owned by hardware differ only in the suppress flag, which separates suppressed from reported completions and proves the +16 step. An end-of-ring list placed next to a valid descriptor shows the wrap to the base, and separate runs cover oversize counts, a failing bus address, a soft reset during a stalled receive, a card error and the clear-by-writing-1 interrupt path.

// File: rtl/chain_dma_pkg.sv
package chain_dma_pkg;

  // descriptor configuration word bits
  localparam int CFG_DIC = 1;
  localparam int CFG_LD  = 2;
  localparam int CFG_CH  = 4;
  localparam int CFG_ER  = 5;
  localparam int CFG_CES = 30;
  localparam int CFG_OWN = 31;

  // control register bits
  localparam int CTL_SRST = 0;
  localparam int CTL_FIXB = 1;
  localparam int CTL_ON   = 7;

  // status / interrupt enable bits
  localparam int ST_TX  = 0;
  localparam int ST_RX  = 1;
  localparam int ST_FBE = 2;
  localparam int ST_DU  = 4;
  localparam int ST_CES = 5;
  localparam int ST_NIS = 8;
  localparam int ST_AIS = 9;
  localparam int ST_HA  = 10;
  localparam int STW    = 11;

  localparam int DESC_WORDS = 4;
  localparam int DESC_BYTES = 4 * DESC_WORDS;

  // register select
  localparam logic [1:0] RA_CTRL = 2'd0;
  localparam logic [1:0] RA_BASE = 2'd1;
  localparam logic [1:0] RA_STAT = 2'd2;
  localparam logic [1:0] RA_IEN  = 2'd3;

  typedef enum logic [1:0] {ADDR_DESC, ADDR_DATA, ADDR_WB} addrSel_e;

  // control -> datapath strobes
  typedef struct packed {
    logic     startWalk;
    logic     capDesc;
    logic     beginXfer;
    logic     capMem;
    logic     capFifo;
    logic     wordDone;
    logic     inXfer;
    logic     finishDesc;
    logic     advance;
    logic     setInvalid;
    logic     setBusErr;
    logic     setAbort;
    addrSel_e addrSel;
  } dmaStrobe_t;

  // datapath -> control flags
  typedef struct packed {
    logic startReq;
    logic softReset;
    logic ownBit;
    logic sizeBad;
    logic lastDesc;
    logic noWords;
    logic fetchLast;
  } dmaFlag_t;

endpackage

// File: rtl/dma_walk_ctrl.sv
module dma_walk_ctrl
  import chain_dma_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  dmaFlag_t   flags,
  input  logic       memAck,
  input  logic       memErr,
  input  logic       dirRx,
  input  logic       txReady,
  input  logic       rxValid,
  output dmaStrobe_t strobe,
  output logic       memReq,
  output logic       memWe,
  output logic       txValid,
  output logic       rxPop
);

  typedef enum logic [3:0] {
    S_IDLE, S_FETCH, S_CHECK, S_DATA, S_TXRD, S_TXPUSH, S_RXPOP, S_RXWR, S_WBACK
  } walkState_e;

  walkState_e state, nextState;

  always_comb begin
    strobe    = '0;
    nextState = state;
    memReq    = 1'b0;
    memWe     = 1'b0;
    txValid   = 1'b0;
    rxPop     = 1'b0;
    strobe.addrSel = ADDR_DESC;
    unique case (state)
      S_IDLE: begin
        if (flags.startReq) begin
          strobe.startWalk = 1'b1;
          nextState = S_FETCH;
        end
      end
      S_FETCH: begin
        memReq = 1'b1;
        if (memAck) begin
          if (memErr) begin
            strobe.setBusErr = 1'b1;
            nextState = S_IDLE;
          end else begin
            strobe.capDesc = 1'b1;
            if (flags.fetchLast) nextState = S_CHECK;
          end
        end
      end
      S_CHECK: begin
        if (!flags.ownBit || flags.sizeBad) begin
          strobe.setInvalid = 1'b1;
          nextState = S_IDLE;
        end else begin
          strobe.beginXfer = 1'b1;
          nextState = S_DATA;
        end
      end
      S_DATA: begin
        strobe.inXfer = 1'b1;
        if (flags.noWords)  nextState = S_WBACK;
        else if (dirRx)     nextState = S_RXPOP;
        else                nextState = S_TXRD;
      end
      S_TXRD: begin
        strobe.inXfer  = 1'b1;
        strobe.addrSel = ADDR_DATA;
        memReq = 1'b1;
        if (memAck) begin
          if (memErr) begin
            strobe.setBusErr = 1'b1;
            nextState = S_IDLE;
          end else begin
            strobe.capMem = 1'b1;
            nextState = S_TXPUSH;
          end
        end
      end
      S_TXPUSH: begin
        strobe.inXfer = 1'b1;
        txValid = 1'b1;
        if (txReady) begin
          strobe.wordDone = 1'b1;
          nextState = S_DATA;
        end
      end
      S_RXPOP: begin
        strobe.inXfer = 1'b1;
        rxPop = rxValid;
        if (rxValid) begin
          strobe.capFifo = 1'b1;
          nextState = S_RXWR;
        end
      end
      S_RXWR: begin
        strobe.inXfer  = 1'b1;
        strobe.addrSel = ADDR_DATA;
        memReq = 1'b1;
        memWe  = 1'b1;
        if (memAck) begin
          if (memErr) begin
            strobe.setBusErr = 1'b1;
            nextState = S_IDLE;
          end else begin
            strobe.wordDone = 1'b1;
            nextState = S_DATA;
          end
        end
      end
      S_WBACK: begin
        strobe.addrSel = ADDR_WB;
        memReq = 1'b1;
        memWe  = 1'b1;
        if (memAck) begin
          if (memErr) begin
            strobe.setBusErr = 1'b1;
            nextState = S_IDLE;
          end else begin
            strobe.finishDesc = 1'b1;
            if (flags.lastDesc) nextState = S_IDLE;
            else begin
              strobe.advance = 1'b1;
              nextState = S_FETCH;
            end
          end
        end
      end
      default: nextState = S_IDLE;
    endcase

    // soft reset overrides everything in the same cycle
    if (flags.softReset) begin
      strobe = '0;
      strobe.addrSel  = ADDR_DESC;
      strobe.setAbort = (state != S_IDLE);
      nextState = S_IDLE;
      memReq  = 1'b0;
      memWe   = 1'b0;
      txValid = 1'b0;
      rxPop   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  // transmit pushes only happen in transmit direction
  assert_tx_dir_R4: assert property (@(posedge clk) disable iff (!rstN)
    txValid |-> !dirRx);

  // receive pops only in receive direction and only with data offered
  assert_rx_dir_R5: assert property (@(posedge clk) disable iff (!rstN)
    rxPop |-> (dirRx && rxValid));

  // a descriptor not owned by hardware ends the walk
  assert_invalid_stop_R3: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_CHECK && !flags.ownBit && !flags.softReset) |=> (state == S_IDLE));

  // an oversize count ends the walk
  assert_oversize_stop_R9: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_CHECK && flags.sizeBad && !flags.softReset) |=> (state == S_IDLE));

  // a failed access ends the walk
  assert_bus_err_stop_R10: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memAck && memErr && !flags.softReset) |=> (state == S_IDLE));

endmodule

// File: rtl/dma_desc_dpath.sv
module dma_desc_dpath
  import chain_dma_pkg::*;
#(
  parameter int MAX_BUF_BYTES = 8192
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [1:0]  regAddr,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  output logic        irq,
  input  dmaStrobe_t  strobe,
  output dmaFlag_t    flags,
  input  logic [31:0] memRdata,
  output logic [31:0] memAddr,
  output logic [31:0] memWdata,
  input  logic [31:0] rxData,
  output logic [31:0] txData,
  input  logic        dirRx,
  input  logic        cardErr
);

  localparam int SZW = $clog2(MAX_BUF_BYTES) + 1;
  localparam int CW  = SZW - 1;

  logic            ctlOn, ctlFix;
  logic [31:0]     baseReg;
  logic [STW-1:0]  statusReg, ieReg;
  logic [31:0]     descAddr, xferAddr, dataReg;
  logic [31:0]     descWord [DESC_WORDS];
  logic [1:0]      wordIdx;
  logic [CW-1:0]   wordsLeft;
  logic            ceSeen;

  logic [31:0]     cfgW, sizeW, bufW, nextW;
  logic [SZW:0]    roundUp;
  logic [CW-1:0]   wordCount;
  logic [31:0]     nextAddr;
  logic [STW-1:0]  setMask, clrMask;
  logic            ctlWr, statWr;

  assign cfgW  = descWord[0];
  assign sizeW = descWord[1];
  assign bufW  = descWord[2];
  assign nextW = descWord[3];

  assign roundUp   = {1'b0, sizeW[SZW-1:0]} + (SZW+1)'(3);
  assign wordCount = roundUp[SZW:2];

  assign ctlWr  = regWrEn && (regAddr == RA_CTRL);
  assign statWr = regWrEn && (regAddr == RA_STAT);

  always_comb begin
    if (cfgW[CFG_CH])      nextAddr = nextW;
    else if (cfgW[CFG_ER]) nextAddr = baseReg;
    else                   nextAddr = descAddr + 32'(DESC_BYTES);
  end

  always_comb begin
    flags.startReq  = ctlWr && regWrData[CTL_ON] && !regWrData[CTL_SRST];
    flags.softReset = ctlWr && regWrData[CTL_SRST];
    flags.ownBit    = cfgW[CFG_OWN];
    flags.sizeBad   = sizeW > 32'(MAX_BUF_BYTES);
    flags.lastDesc  = cfgW[CFG_LD];
    flags.noWords   = (wordsLeft == '0);
    flags.fetchLast = (wordIdx == 2'd3);
  end

  always_comb begin
    unique case (strobe.addrSel)
      ADDR_DATA: memAddr = xferAddr;
      ADDR_WB:   memAddr = descAddr;
      default:   memAddr = descAddr + {28'd0, wordIdx, 2'b00};
    endcase
    if (strobe.addrSel == ADDR_WB)
      memWdata = {1'b0, cfgW[CFG_CES] | ceSeen, cfgW[29:0]};
    else
      memWdata = dataReg;
  end

  assign txData = dataReg;

  always_comb begin
    setMask = '0;
    if (strobe.finishDesc) begin
      if (!cfgW[CFG_DIC] || cfgW[CFG_LD]) begin
        setMask[dirRx ? ST_RX : ST_TX] = 1'b1;
        setMask[ST_NIS] = 1'b1;
      end
      if (ceSeen) begin
        setMask[ST_CES] = 1'b1;
        setMask[ST_AIS] = 1'b1;
      end
    end
    if (strobe.setInvalid) begin
      setMask[ST_DU]  = 1'b1;
      setMask[ST_AIS] = 1'b1;
    end
    if (strobe.setBusErr) begin
      setMask[ST_FBE] = 1'b1;
      setMask[ST_AIS] = 1'b1;
    end
    if (strobe.setAbort) begin
      setMask[ST_HA]  = 1'b1;
      setMask[ST_AIS] = 1'b1;
    end
    clrMask = statWr ? regWrData[STW-1:0] : '0;
  end

  // software registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctlOn     <= 1'b0;
      ctlFix    <= 1'b0;
      baseReg   <= '0;
      ieReg     <= '0;
      statusReg <= '0;
    end else begin
      if (ctlWr) begin
        if (regWrData[CTL_SRST]) begin
          ctlOn  <= 1'b0;
          ctlFix <= 1'b0;
        end else begin
          ctlOn  <= regWrData[CTL_ON];
          ctlFix <= regWrData[CTL_FIXB];
        end
      end
      if (regWrEn && regAddr == RA_BASE) baseReg <= regWrData;
      if (regWrEn && regAddr == RA_IEN)  ieReg   <= regWrData[STW-1:0];
      statusReg <= (statusReg & ~clrMask) | setMask;
    end
  end

  // walk datapath
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      descAddr  <= '0;
      xferAddr  <= '0;
      dataReg   <= '0;
      wordIdx   <= '0;
      wordsLeft <= '0;
      ceSeen    <= 1'b0;
      for (int i = 0; i < DESC_WORDS; i++) descWord[i] <= '0;
    end else begin
      if (strobe.startWalk) begin
        descAddr <= baseReg;
        wordIdx  <= '0;
      end
      if (strobe.advance) begin
        descAddr <= nextAddr;
        wordIdx  <= '0;
      end
      if (strobe.capDesc) begin
        descWord[wordIdx] <= memRdata;
        wordIdx <= wordIdx + 2'd1;
      end
      if (strobe.beginXfer) begin
        xferAddr  <= bufW;
        wordsLeft <= wordCount;
        ceSeen    <= 1'b0;
      end else if (strobe.inXfer && cardErr) begin
        ceSeen <= 1'b1;
      end
      if (strobe.capMem)  dataReg <= memRdata;
      if (strobe.capFifo) dataReg <= rxData;
      if (strobe.wordDone) begin
        xferAddr  <= xferAddr + 32'd4;
        wordsLeft <= wordsLeft - CW'(1);
      end
    end
  end

  always_comb begin
    unique case (regAddr)
      RA_CTRL: regRdData = {24'd0, ctlOn, 5'd0, ctlFix, 1'b0};
      RA_BASE: regRdData = baseReg;
      RA_STAT: regRdData = {{(32-STW){1'b0}}, statusReg};
      default: regRdData = {{(32-STW){1'b0}}, ieReg};
    endcase
  end

  assign irq = |(statusReg & ieReg);

  // a reported completion always carries the normal summary
  assert_done_summary_R8: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(statusReg[ST_TX]) || $rose(statusReg[ST_RX])) |-> statusReg[ST_NIS]);

  // abort leaves host-abort status and a cleared control register
  assert_abort_state_R12: assert property (@(posedge clk) disable iff (!rstN)
    strobe.setAbort |=> (statusReg[ST_HA] && !ctlOn));

  // a status bit with no new event is cleared by writing 1
  assert_w1c_R11: assert property (@(posedge clk) disable iff (!rstN)
    (statWr && regWrData[ST_HA] && !strobe.setAbort) |=> !statusReg[ST_HA]);

endmodule

// File: rtl/chain_dma_engine.sv
module chain_dma_engine
  import chain_dma_pkg::*;
#(
  parameter int MAX_BUF_BYTES = 8192
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [1:0]  regAddr,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  output logic        irq,
  output logic        memReq,
  output logic        memWe,
  output logic [31:0] memAddr,
  output logic [31:0] memWdata,
  input  logic        memAck,
  input  logic        memErr,
  input  logic [31:0] memRdata,
  input  logic        dirRx,
  input  logic        cardErr,
  output logic        txValid,
  input  logic        txReady,
  output logic [31:0] txData,
  input  logic        rxValid,
  output logic        rxPop,
  input  logic [31:0] rxData
);

  dmaStrobe_t strobeW;
  dmaFlag_t   flagsW;

  dma_walk_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .flags   (flagsW),
    .memAck  (memAck),
    .memErr  (memErr),
    .dirRx   (dirRx),
    .txReady (txReady),
    .rxValid (rxValid),
    .strobe  (strobeW),
    .memReq  (memReq),
    .memWe   (memWe),
    .txValid (txValid),
    .rxPop   (rxPop)
  );

  dma_desc_dpath #(.MAX_BUF_BYTES(MAX_BUF_BYTES)) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .irq       (irq),
    .strobe    (strobeW),
    .flags     (flagsW),
    .memRdata  (memRdata),
    .memAddr   (memAddr),
    .memWdata  (memWdata),
    .rxData    (rxData),
    .txData    (txData),
    .dirRx     (dirRx),
    .cardErr   (cardErr)
  );

  // a pending access keeps its address and kind until acknowledged
  assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck && !flagsW.softReset) |=>
      (flagsW.softReset || (memReq && $stable(memAddr) && $stable(memWe))));

  // write-back never hands the descriptor back still owned
  assert_wb_own_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWe && strobeW.addrSel == ADDR_WB) |-> !memWdata[CFG_OWN]);

endmodule

// File: tb/chain_dma_engine_bench.sv
`timescale 1ns/1ps
module chain_dma_engine_bench;

  localparam logic [31:0] OWN = 32'h8000_0000;
  localparam logic [31:0] CES = 32'h4000_0000;
  localparam logic [31:0] ER  = 32'h20;
  localparam logic [31:0] CH  = 32'h10;
  localparam logic [31:0] FD  = 32'h08;
  localparam logic [31:0] LD  = 32'h04;
  localparam logic [31:0] DIC = 32'h02;
  localparam int NVEC = 5;
  // stimulus: direction, byte count, expected words
  localparam logic        VEC_DIR [NVEC] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0};
  localparam logic [31:0] VEC_SIZE[NVEC] = '{32'd4, 32'd13, 32'd32, 32'd7, 32'd0};
  localparam int          VEC_WDS [NVEC] = '{1, 4, 8, 2, 0};

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rstN, regWrEn, irq, memReq, memWe, memAck, memErr;
  logic [1:0]  regAddr;
  logic [31:0] regWrData, regRdData, memAddr, memWdata, memRdata;
  logic        dirRx, cardErr, txValid, txReady, rxValid, rxPop;
  logic [31:0] txData, rxData;

  chain_dma_engine u_chain_dma_engine (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .irq(irq),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memAck(memAck), .memErr(memErr), .memRdata(memRdata),
    .dirRx(dirRx), .cardErr(cardErr), .txValid(txValid), .txReady(txReady),
    .txData(txData), .rxValid(rxValid), .rxPop(rxPop), .rxData(rxData)
  );

  // behavioural memory, 4 KiB; addresses at or above 0x1000 fail
  logic [31:0] mem [1024];
  logic        pokeEn;
  logic [31:0] pokeAddr, pokeVal;
  always @(posedge clk) begin
    memAck <= memReq && !memAck;
    memErr <= memReq && !memAck && (memAddr >= 32'h1000);
    if (memReq && !memAck) begin
      memRdata <= mem[memAddr[11:2]];
      if (memWe && memAddr < 32'h1000) mem[memAddr[11:2]] <= memWdata;
    end
    if (pokeEn) mem[pokeAddr[11:2]] <= pokeVal;
  end

  // FIFO models
  logic [31:0] txLog [256];
  int txCnt = 0;
  int rxCnt = 0;
  logic stallEn, rxEn;
  assign rxValid = rxEn;
  assign rxData  = 32'hC0DE_0000 + rxCnt;
  always @(posedge clk) begin
    txReady <= stallEn ? ~txReady : 1'b1;
    if (txValid && txReady) begin
      txLog[txCnt[7:0]] <= txData;
      txCnt <= txCnt + 1;
    end
    if (rxPop) rxCnt <= rxCnt + 1;
  end

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic poke(input logic [31:0] a, input logic [31:0] v);
    @(negedge clk);
    pokeEn = 1'b1; pokeAddr = a; pokeVal = v;
    @(negedge clk);
    pokeEn = 1'b0;
  endtask

  task automatic putDesc(input logic [31:0] a, input logic [31:0] cfg,
                         input logic [31:0] sz, input logic [31:0] buff,
                         input logic [31:0] nxt);
    poke(a, cfg); poke(a + 4, sz); poke(a + 8, buff); poke(a + 12, nxt);
  endtask

  task automatic waitStatus(input logic [31:0] mask, output logic [31:0] st);
    for (int n = 0; n < 4000; n++) begin
      regRead(2'd2, st);
      if ((st & mask) != 0) break;
    end
    repeat (6) @(negedge clk);
    regRead(2'd2, st);
  endtask

  task automatic clearAll();
    regWrite(2'd2, 32'h7FF);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] st, rd;
    int t0, r0;
    rstN = 1'b0; regWrEn = 1'b0; regAddr = '0; regWrData = '0;
    dirRx = 1'b0; cardErr = 1'b0; stallEn = 1'b0; rxEn = 1'b1;
    pokeEn = 1'b0; pokeAddr = '0; pokeVal = '0; txReady = 1'b1;
    for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      regRead(a[1:0], rd);
      chk("R1 register reset", rd, 32'h0);
    end
    chk("R1 irq low", {31'd0, irq}, 32'd0);
    chk("R1 no memory request", {31'd0, memReq}, 32'd0);
    chk("R1 no FIFO traffic", {30'd0, txValid, rxPop}, 32'd0);

    regWrite(2'd1, 32'h100);

    // vector table: single-descriptor lists
    for (int v = 0; v < NVEC; v++) begin
      clearAll();
      for (int k = 0; k < 8; k++) poke(32'h400 + 4 * k, 32'hA000_0000 + 16 * v + k);
      putDesc(32'h100, OWN | FD | LD | ER, VEC_SIZE[v], 32'h400, 32'h0);
      dirRx = VEC_DIR[v];
      t0 = txCnt; r0 = rxCnt;
      regWrite(2'd0, 32'h80);
      waitStatus(32'h300, st);
      chk($sformatf("R8 vec%0d completion status", v), st,
          VEC_DIR[v] ? 32'h102 : 32'h101);
      chk($sformatf("R6 vec%0d write-back at base (R2)", v), mem[32'h100 >> 2], FD | LD | ER);
      if (!VEC_DIR[v]) begin
        chk($sformatf("R4 vec%0d pushed words", v), txCnt - t0, VEC_WDS[v]);
        for (int k = 0; k < VEC_WDS[v]; k++)
          chk($sformatf("R4 vec%0d word %0d", v, k), txLog[(t0 + k) % 256],
              32'hA000_0000 + 16 * v + k);
      end else begin
        chk($sformatf("R5 vec%0d popped words", v), rxCnt - r0, VEC_WDS[v]);
        for (int k = 0; k < VEC_WDS[v]; k++)
          chk($sformatf("R5 vec%0d memory word %0d", v, k), mem[(32'h400 >> 2) + k],
              32'hC0DE_0000 + r0 + k);
      end
    end

    // R7 chained list with scattered pointers, suppress on first two
    clearAll();
    dirRx = 1'b0; stallEn = 1'b1;
    for (int k = 0; k < 2; k++) begin
      poke(32'h400 + 4 * k, 32'h1111_0000 + k);
      poke(32'h600 + 4 * k, 32'h2222_0000 + k);
      poke(32'h800 + 4 * k, 32'h3333_0000 + k);
    end
    putDesc(32'h100, OWN | FD | CH | DIC, 32'd8, 32'h400, 32'h200);
    putDesc(32'h200, OWN | CH | DIC, 32'd4, 32'h600, 32'h140);
    putDesc(32'h140, OWN | LD, 32'd8, 32'h800, 32'h0);
    t0 = txCnt;
    regWrite(2'd0, 32'h80);
    waitStatus(32'h300, st);
    chk("R8 chain reports only last", st, 32'h101);
    chk("R7 chain word count", txCnt - t0, 5);
    chk("R7 chain word 0", txLog[(t0 + 0) % 256], 32'h1111_0000);
    chk("R7 chain word 1", txLog[(t0 + 1) % 256], 32'h1111_0001);
    chk("R7 chain word 2", txLog[(t0 + 2) % 256], 32'h2222_0000);
    chk("R7 chain word 3", txLog[(t0 + 3) % 256], 32'h3333_0000);
    chk("R7 chain word 4", txLog[(t0 + 4) % 256], 32'h3333_0001);
    chk("R6 chain desc1 handed back", mem[32'h200 >> 2], CH | DIC);
    chk("R6 chain desc2 handed back", mem[32'h140 >> 2], LD);
    stallEn = 1'b0;

    // R8 suppressed completion, contiguous step, then unowned descriptor
    clearAll();
    regWrite(2'd1, 32'h180);
    putDesc(32'h180, OWN | FD | DIC, 32'd4, 32'h400, 32'h0);
    putDesc(32'h190, 32'h0, 32'd4, 32'h400, 32'h0);
    t0 = txCnt;
    regWrite(2'd0, 32'h80);
    waitStatus(32'h200, st);
    chk("R8 suppressed then R3 invalid", st, 32'h210);
    chk("R7 contiguous pushes", txCnt - t0, 1);
    chk("R3 unowned not written back", mem[32'h190 >> 2], 32'h0);

    clearAll();
    putDesc(32'h180, OWN | FD, 32'd4, 32'h400, 32'h0);
    regWrite(2'd0, 32'h80);
    waitStatus(32'h200, st);
    chk("R8 reported then R3 invalid", st, 32'h311);

    // R7 end of ring wraps to base
    clearAll();
    regWrite(2'd1, 32'h100);
    putDesc(32'h100, OWN | FD | ER, 32'd4, 32'h400, 32'h0);
    putDesc(32'h110, OWN | LD, 32'd4, 32'h500, 32'h0);
    t0 = txCnt;
    regWrite(2'd0, 32'h80);
    waitStatus(32'h200, st);
    chk("R7 ring wrap hits handed-back base", st, 32'h311);
    chk("R7 ring pushes", txCnt - t0, 1);

    // R9 oversize count
    clearAll();
    putDesc(32'h100, OWN | LD, 32'd8196, 32'h400, 32'h0);
    t0 = txCnt;
    regWrite(2'd0, 32'h80);
    waitStatus(32'h200, st);
    chk("R9 oversize status", st, 32'h210);
    chk("R9 oversize no data", txCnt - t0, 0);
    chk("R9 oversize still owned", mem[32'h100 >> 2], OWN | LD);

    // R10 bus error on buffer access
    clearAll();
    putDesc(32'h100, OWN | LD, 32'd8, 32'h2000, 32'h0);
    t0 = txCnt;
    regWrite(2'd0, 32'h80);
    waitStatus(32'h200, st);
    chk("R10 bus error status", st, 32'h204);
    chk("R10 bus error no push", txCnt - t0, 0);

    // R12 soft reset during stalled receive
    clearAll();
    dirRx = 1'b1; rxEn = 1'b0;
    putDesc(32'h100, OWN | LD, 32'd8, 32'h400, 32'h0);
    regWrite(2'd0, 32'h82);
    repeat (30) @(negedge clk);
    regWrite(2'd0, 32'h01);
    repeat (4) @(negedge clk);
    regRead(2'd2, st);
    chk("R12 host abort status", st, 32'h600);
    regRead(2'd0, rd);
    chk("R12 control cleared", rd, 32'h0);
    chk("R12 memory idle", {31'd0, memReq}, 32'd0);
    chk("R12 no write-back", mem[32'h100 >> 2], OWN | LD);

    // R11 interrupt enable and write-1-to-clear
    regWrite(2'd3, 32'h400);
    chk("R11 irq on enabled bit", {31'd0, irq}, 32'd1);
    regWrite(2'd2, 32'h400);
    regRead(2'd2, st);
    chk("R11 partial clear", st, 32'h200);
    chk("R11 irq off", {31'd0, irq}, 32'd0);
    regWrite(2'd3, 32'h200);
    chk("R11 irq other bit", {31'd0, irq}, 32'd1);
    regWrite(2'd2, 32'h7FF);
    regRead(2'd2, st);
    chk("R11 full clear", st, 32'h0);
    chk("R11 irq after clear", {31'd0, irq}, 32'd0);

    // R6 card error during receive
    clearAll();
    putDesc(32'h100, OWN | FD | LD, 32'd8, 32'h700, 32'h0);
    r0 = rxCnt;
    regWrite(2'd0, 32'h80);
    repeat (30) @(negedge clk);
    cardErr = 1'b1;
    @(negedge clk);
    cardErr = 1'b0;
    rxEn = 1'b1;
    waitStatus(32'h100, st);
    chk("R6 card error status", st, 32'h322);
    chk("R6 card error write-back", mem[32'h100 >> 2], FD | LD | CES);
    chk("R5 card error data 0", mem[32'h700 >> 2], 32'hC0DE_0000 + r0);
    chk("R5 card error data 1", mem[(32'h700 >> 2) + 1], 32'hC0DE_0000 + r0 + 1);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule